// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Clear Unit

This unit gathers the four event sources of an SPI controller into a set of sticky status bits and drives one interrupt line toward the interrupt controller. Each source pulses for one clock when its condition occurs: a transfer finished, a received word is waiting, the receive side overflowed, or the transmit side ran dry. The pulse latches into a raw status bit, which stays set until software clears it by writing a one to the matching bit of the clear register.

Software enables each source through four bits of the controller's control word. The unit offers two readable views: the raw view shows every latched event whatever its enable, and the masked view shows only the latched events whose enable is set. The interrupt line is high exactly when the masked view is non-zero, so a handler on a shared line that reads a zero masked word can tell the request came from elsewhere.

Top module: `spi_irq_unit`

## Requirements
- R1: Raw and masked status bits are ordered by source: bit 0 transfer finished, bit 1 receive word ready, bit 2 receive overflow, bit 3 transmit underrun.
- R2: A one-cycle event pulse sets its raw status bit after the next clock edge, and the bit then stays set until it is cleared; raw bits never set without an event.
- R3: Control word bit 4 enables source 1 (receive ready), bit 5 enables source 0 (transfer finished), bit 6 enables source 2 and bit 7 enables source 3; every other control bit has no effect on the enables. An enable change shows in the masked view after the next clock edge.
- R4: The masked view equals the raw view ANDed with the enables; events latch into the raw view even while their source is disabled.
- R5: With the clear strobe high, each one in the clear data clears the matching raw bit after the next clock edge, and each zero leaves its bit unchanged.
- R6: Clear data presented while the clear strobe is low has no effect on the raw view.
- R7: When an event pulse and a clear of the same bit arrive in the same cycle, the event wins and the bit stays set.
- R8: The interrupt output is high exactly when the masked view is non-zero, and it is driven from a register in the default build.
- R9: Reset clears every raw bit and every enable, and holds the interrupt output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 4 | Event pulses, one bit per source in the R1 order |
| ctrl_i | input | 32 | Controller control word; bits 7:4 carry the enables |
| clr_we_i | input | 1 | Write strobe of the clear register |
| clr_data_i | input | 4 | Clear register write data, one bit per source |
| raw_o | output | 4 | Raw latched status |
| masked_o | output | 4 | Latched status gated by the enables |
| irq_o | output | 1 | Interrupt request line |

## Verification
The bench builds the unit with its defaults: a 32-bit control word, enables starting at bit 4 and a registered interrupt output. With these values the swapped order of the two lowest enables, the control bits outside the enable field and the event-against-clear collision all lie on ports the bench drives, so each can be exercised directly. The registered-line variant is the one whose timing against the masked view is checked every cycle.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int unsigned SRC_N = 4;

   typedef enum int unsigned {
      SRC_XFER_DONE = 0,
      SRC_RX_READY  = 1,
      SRC_RX_OVF    = 2,
      SRC_TX_UNDER  = 3
   } src_e;

   typedef logic [SRC_N-1:0] src_vec_t;

   // Enable slot k of the control field drives the source returned here (R3).
   function automatic int unsigned slot_to_src(input int unsigned slot);
      case (slot)
         0: return int'(SRC_RX_READY);
         1: return int'(SRC_XFER_DONE);
         default: return slot;
      endcase
   endfunction
endpackage

// File: rtl/spi_irq_en_map.sv
module spi_irq_en_map
   import spi_irq_pkg::*;
#(
   parameter int unsigned CTRL_W = 32,
   parameter int unsigned EN_LSB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl_i,
   output src_vec_t          en_next_o,
   output src_vec_t          en_q_o
);
   localparam int unsigned EN_MSB = EN_LSB + SRC_N - 1;

   initial begin
      assert (EN_MSB < CTRL_W)
         else $error("enable field does not fit in the control word");
   end

   logic unused_ctrl;
   assign unused_ctrl = ^ctrl_i;

   for (genvar g = 0; g < SRC_N; g++) begin : g_slot
      assign en_next_o[slot_to_src(g)] = ctrl_i[EN_LSB + g];
   end

   src_vec_t en_q;
   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_next_o;
   end
   assign en_q_o = en_q;
endmodule

// File: rtl/spi_irq_latch.sv
module spi_irq_latch
   import spi_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t evt_i,
   input  logic     clr_we_i,
   input  src_vec_t clr_data_i,
   output src_vec_t raw_next_o,
   output src_vec_t raw_q_o
);
   src_vec_t raw_q;

   for (genvar i = 0; i < SRC_N; i++) begin : g_bit
      logic kill;
      assign kill          = clr_we_i & clr_data_i[i];
      assign raw_next_o[i] = evt_i[i] | (raw_q[i] & ~kill);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= raw_next_o;
   end
   assign raw_q_o = raw_q;
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
   import spi_irq_pkg::*;
#(
   parameter int unsigned CTRL_W  = 32,
   parameter int unsigned EN_LSB  = 4,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_N-1:0]  evt_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic              clr_we_i,
   input  logic [SRC_N-1:0]  clr_data_i,
   output logic [SRC_N-1:0]  raw_o,
   output logic [SRC_N-1:0]  masked_o,
   output logic              irq_o
);
   initial begin
      assert (CTRL_W >= SRC_N) else $error("control word too narrow");
   end

   src_vec_t en_next, en_q, raw_next, raw_q;

   spi_irq_en_map #(.CTRL_W(CTRL_W), .EN_LSB(EN_LSB)) u_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_i    (ctrl_i),
      .en_next_o (en_next),
      .en_q_o    (en_q)
   );

   spi_irq_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .clr_we_i   (clr_we_i),
      .clr_data_i (clr_data_i),
      .raw_next_o (raw_next),
      .raw_q_o    (raw_q)
   );

   assign raw_o    = raw_q;
   assign masked_o = raw_q & en_q;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(raw_next & en_next);
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |masked_o;
   end
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
   import spi_irq_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [SRC_N-1:0] evt_i,
   input logic             clr_we_i,
   input logic [SRC_N-1:0] clr_data_i,
   input logic [SRC_N-1:0] raw_o,
   input logic [SRC_N-1:0] masked_o,
   input logic             irq_o
);
   AST_IRQ_TRACKS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (masked_o != '0)); // R8
   AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_o & ~raw_o) == '0); // R4
   AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i != '0 |=> (raw_o & $past(evt_i)) == $past(evt_i)); // R7
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (raw_o & ~$past(raw_o) & ~$past(evt_i)) == '0); // R2
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_i |=> (raw_o & $past(clr_data_i) & ~$past(evt_i)) == '0); // R5
   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we_i |=> (raw_o & $past(raw_o)) == $past(raw_o)); // R6
endmodule

bind spi_irq_unit spi_irq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_i      (evt_i),
   .clr_we_i   (clr_we_i),
   .clr_data_i (clr_data_i),
   .raw_o      (raw_o),
   .masked_o   (masked_o),
   .irq_o      (irq_o)
);

// File: tb/spi_irq_unit_tb.sv
module spi_irq_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  evt_i = '0;
   logic [31:0] ctrl_i = '0;
   logic        clr_we_i = 1'b0;
   logic [3:0]  clr_data_i = '0;
   logic [3:0]  raw_o, masked_o;
   logic        irq_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   spi_irq_unit u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ctrl_i(ctrl_i),
      .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
      .raw_o(raw_o), .masked_o(masked_o), .irq_o(irq_o)
   );

   typedef struct packed {
      logic [3:0] evt;
      logic [7:0] ctl;
      logic       we;
      logic [3:0] clr;
      logic [3:0] raw;
      logic [3:0] msk;
      logic       irq;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t TBL [NV] = '{
      '{4'b0001, 8'h00, 1'b0, 4'h0, 4'b0001, 4'b0000, 1'b0}, // R1 R4 latched while disabled
      '{4'b0100, 8'h00, 1'b0, 4'h0, 4'b0101, 4'b0000, 1'b0},
      '{4'b0000, 8'h20, 1'b0, 4'h0, 4'b0101, 4'b0001, 1'b1}, // R3 bit5 -> src0
      '{4'b0000, 8'h10, 1'b0, 4'h0, 4'b0101, 4'b0000, 1'b0}, // R3 bit4 -> src1
      '{4'b0010, 8'h10, 1'b0, 4'h0, 4'b0111, 4'b0010, 1'b1},
      '{4'b0000, 8'h40, 1'b0, 4'h0, 4'b0111, 4'b0100, 1'b1},
      '{4'b0000, 8'h80, 1'b0, 4'h0, 4'b0111, 4'b0000, 1'b0},
      '{4'b1000, 8'h80, 1'b0, 4'h0, 4'b1111, 4'b1000, 1'b1},
      '{4'b0000, 8'h0F, 1'b0, 4'h0, 4'b1111, 4'b0000, 1'b0}, // R3 low bits ignored
      '{4'b0000, 8'hF0, 1'b0, 4'hF, 4'b1111, 4'b1111, 1'b1}, // R6 no strobe
      '{4'b0000, 8'hF0, 1'b1, 4'h0, 4'b1111, 4'b1111, 1'b1}, // R5 zeros keep
      '{4'b0000, 8'hF0, 1'b1, 4'h5, 4'b1010, 4'b1010, 1'b1}, // R5
      '{4'b0010, 8'hF0, 1'b1, 4'h2, 4'b1010, 4'b1010, 1'b1}, // R7 event wins
      '{4'b0000, 8'hF0, 1'b1, 4'hA, 4'b0000, 4'b0000, 1'b0}, // R8 line drops
      '{4'b1001, 8'hF0, 1'b1, 4'h1, 4'b1001, 4'b1001, 1'b1}, // R7
      '{4'b0000, 8'h00, 1'b0, 4'h0, 4'b1001, 4'b0000, 1'b0},
      '{4'b0000, 8'h00, 1'b1, 4'hF, 4'b0000, 4'b0000, 1'b0}
   };

   task automatic chk(input string req, input int act, input int exp_v);
      n_run++;
      if (act != exp_v) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp_v);
      end
   endtask

   task automatic step(input logic [3:0] e, input logic [31:0] c,
                       input logic we, input logic [3:0] cl);
      @(negedge clk);
      evt_i = e; ctrl_i = c; clr_we_i = we; clr_data_i = cl;
      @(posedge clk);
      @(negedge clk);
      evt_i = '0; clr_we_i = 1'b0; clr_data_i = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      ctrl_i = 32'h0000_00F0;
      evt_i = 4'hF;
      repeat (3) @(negedge clk);
      chk("R9 raw", int'(raw_o), 0);
      chk("R9 masked", int'(masked_o), 0);
      chk("R9 irq", int'(irq_o), 0);
      evt_i = '0; ctrl_i = '0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         step(TBL[k].evt, {24'h0, TBL[k].ctl}, TBL[k].we, TBL[k].clr);
         chk($sformatf("R2 raw row %0d", k), int'(raw_o), int'(TBL[k].raw));
         chk($sformatf("R4 masked row %0d", k), int'(masked_o), int'(TBL[k].msk));
         chk($sformatf("R8 irq row %0d", k), int'(irq_o), int'(TBL[k].irq));
      end

      // R1: each source alone lands in its own bit
      for (int s = 0; s < 4; s++) begin
         step(4'(1 << s), 32'h0, 1'b0, 4'h0);
         chk($sformatf("R1 source %0d", s), int'(raw_o), 1 << s);
         step(4'h0, 32'h0, 1'b1, 4'hF);
      end

      // R3: control bits outside 7:4 leave the enables off
      step(4'hF, 32'hFFFF_FF0F, 1'b0, 4'h0);
      chk("R3 upper bits", int'(masked_o), 0);
      chk("R3 upper bits irq", int'(irq_o), 0);
      step(4'h0, 32'h0000_0030, 1'b0, 4'h0);
      chk("R3 swapped pair", int'(masked_o), 3);

      // R9: reset mid-run with state present
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R9 reset raw", int'(raw_o), 0);
      chk("R9 reset irq", int'(irq_o), 0);
      rst_n = 1'b1;
      step(4'h2, 32'h0000_0030, 1'b0, 4'h0);
      chk("R8 after reset", int'(irq_o), 1);

      finish_run();
   end
endmodule